// File: doc/BRIEF.md
# Selectable Error Rate Counter

This block measures how often a chosen class of decoding error occurs. It takes four per-cycle error counts from the receive chain: raw bit errors from the demodulator, bit errors from the inner decoder, byte errors from the inner decoder, and packets the outer decoder could not correct. It adds the selected count into a running total over a window measured in byte-clock strobes. When the window closes, the total is copied into a held result register that a host can read, a one-cycle done pulse is raised, and a new window begins from zero.

A single control write selects the source and a 2-bit window code. The window is 2^(BASE_LOG2 + 2*code) byte strobes long, which gives 2^12 to 2^18 bytes with the default parameters. The running total stops at its all-ones value instead of wrapping, so a window with too many errors reads as full scale.

Top module: `err_rate_meter`

## Requirements
- R1: After reset, `rate_count` is 0, `window_done` is 0, the selected source is 0 and the window code is 0.
- R2: The source code selects which input is counted: 0 selects `ev_demod_bit`, 1 selects `ev_inner_bit`, 2 selects `ev_inner_byte` and 3 selects `ev_pkt_fail`. The unselected inputs have no effect on `rate_count`.
- R3: A window lasts exactly 2^(BASE_LOG2 + 2*code) cycles in which `byte_tick` is high. Cycles with `byte_tick` low do not advance the window.
- R4: In the cycle after the window's last `byte_tick`, `rate_count` holds the sum of the selected input over every counted cycle of that window, including the last one, and `window_done` is high for exactly that one cycle. `rate_count` changes at no other time.
- R5: The running total restarts at zero after each window, so consecutive windows with the same input give the same result.
- R6: The running total saturates at 2^CNTW - 1 and never wraps.
- R7: A cycle with `cfg_we` high loads `cfg_src` and `cfg_period`, clears the running total and the window position, and discards that cycle's events and strobe. `rate_count` keeps its value, and no `window_done` occurs until a full new window has elapsed.
- R8: Each input is a count of 0 to 2^EVW - 1 events for that cycle, and the whole value is added in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_demod_bit | input | EVW | Demodulator bit errors this cycle |
| ev_inner_bit | input | EVW | Inner decoder bit errors this cycle |
| ev_inner_byte | input | EVW | Inner decoder byte errors this cycle |
| ev_pkt_fail | input | EVW | Uncorrectable packets this cycle |
| byte_tick | input | 1 | One decoded byte passed in this cycle |
| cfg_we | input | 1 | Control write strobe |
| cfg_src | input | 2 | Source code to load |
| cfg_period | input | 2 | Window code to load |
| rate_count | output | CNTW | Held error count of the last finished window |
| window_done | output | 1 | One-cycle pulse when a window finishes |

## Verification
The properties assume that a window is at least two byte strobes long. Done pulses then can never touch, and `rate_count` changes only beside a pulse. They also assume that `cfg_we` is a plain level sampled on the clock, with no relation to `byte_tick`. The bench drives every input at the falling edge, keeps BASE_LOG2 at 4 so that each window is at least 16 strobes, and issues control writes both between windows and in the middle of one.

// File: rtl/erm_pkg.sv
package erm_pkg;

    typedef enum logic [1:0] {
        SRC_DEMOD_BIT  = 2'd0,
        SRC_INNER_BIT  = 2'd1,
        SRC_INNER_BYTE = 2'd2,
        SRC_PKT_FAIL   = 2'd3
    } err_src_e;

    // window exponent for a given code: base + 2*code
    function automatic int unsigned win_shift(input int unsigned base, input logic [1:0] code);
        return base + 2 * int'(code);
    endfunction

endpackage

// File: rtl/erm_src_mux.sv
module erm_src_mux #(
    parameter int EVW = 3
) (
    input  erm_pkg::err_src_e sel,
    input  logic [EVW-1:0]    ev_demod_bit,
    input  logic [EVW-1:0]    ev_inner_bit,
    input  logic [EVW-1:0]    ev_inner_byte,
    input  logic [EVW-1:0]    ev_pkt_fail,
    output logic [EVW-1:0]    ev_sel
);
    always_comb begin
        unique case (sel)
            erm_pkg::SRC_DEMOD_BIT:  ev_sel = ev_demod_bit;
            erm_pkg::SRC_INNER_BIT:  ev_sel = ev_inner_bit;
            erm_pkg::SRC_INNER_BYTE: ev_sel = ev_inner_byte;
            default:                 ev_sel = ev_pkt_fail;
        endcase
    end
endmodule

// File: rtl/erm_window_timer.sv
module erm_window_timer #(
    parameter int BASE_LOG2 = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       tick,
    input  logic [1:0] code,
    output logic       win_end
);
    localparam int TW = BASE_LOG2 + 6;

    logic [TW-1:0] pos_d, pos_q;
    logic [TW-1:0] last_pos;

    always_comb begin
        // 2^shift - 1; at the largest code the shift equals TW and wraps to all ones
        last_pos = (TW'(1) << erm_pkg::win_shift(BASE_LOG2, code)) - TW'(1);
        win_end  = 1'b0;
        pos_d    = pos_q;
        if (clear) begin
            pos_d = '0;
        end else if (tick) begin
            if (pos_q == last_pos) begin
                win_end = 1'b1;
                pos_d   = '0;
            end else begin
                pos_d = pos_q + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/erm_sat_add.sv
module erm_sat_add #(
    parameter int CNTW = 16,
    parameter int EVW  = 3
) (
    input  logic [CNTW-1:0] acc,
    input  logic [EVW-1:0]  inc,
    output logic [CNTW-1:0] sum
);
    localparam int SW = CNTW + 1;

    logic [SW-1:0] wide;

    always_comb begin
        wide = {1'b0, acc} + SW'(inc);
        sum  = wide[CNTW] ? {CNTW{1'b1}} : wide[CNTW-1:0];
    end
endmodule

// File: rtl/err_rate_meter.sv
module err_rate_meter #(
    parameter int BASE_LOG2 = 12,
    parameter int CNTW      = 16,
    parameter int EVW       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EVW-1:0]  ev_demod_bit,
    input  logic [EVW-1:0]  ev_inner_bit,
    input  logic [EVW-1:0]  ev_inner_byte,
    input  logic [EVW-1:0]  ev_pkt_fail,
    input  logic            byte_tick,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_src,
    input  logic [1:0]      cfg_period,
    output logic [CNTW-1:0] rate_count,
    output logic            window_done
);
    typedef struct packed {
        erm_pkg::err_src_e src;
        logic [1:0]        period;
        logic [CNTW-1:0]   run;
        logic [CNTW-1:0]   held;
        logic              done;
    } meter_st_t;

    meter_st_t st_d, st_q;

    logic [EVW-1:0]  ev_sel;
    logic [CNTW-1:0] run_sum;
    logic            win_end;

    erm_src_mux #(.EVW(EVW)) u_mux (
        .sel           (st_q.src),
        .ev_demod_bit  (ev_demod_bit),
        .ev_inner_bit  (ev_inner_bit),
        .ev_inner_byte (ev_inner_byte),
        .ev_pkt_fail   (ev_pkt_fail),
        .ev_sel        (ev_sel)
    );

    erm_window_timer #(.BASE_LOG2(BASE_LOG2)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cfg_we),
        .tick    (byte_tick),
        .code    (st_q.period),
        .win_end (win_end)
    );

    erm_sat_add #(.CNTW(CNTW), .EVW(EVW)) u_add (
        .acc (st_q.run),
        .inc (ev_sel),
        .sum (run_sum)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (cfg_we) begin
            st_d.src    = erm_pkg::err_src_e'(cfg_src);
            st_d.period = cfg_period;
            st_d.run    = '0;
        end else if (win_end) begin
            st_d.held = run_sum;
            st_d.done = 1'b1;
            st_d.run  = '0;
        end else begin
            st_d.run = run_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.src    <= erm_pkg::SRC_DEMOD_BIT;
            st_q.period <= 2'd0;
            st_q.run    <= '0;
            st_q.held   <= '0;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_count  = st_q.held;
    assign window_done = st_q.done;
endmodule

// File: rtl/erm_checker.sv
module erm_checker #(
    parameter int CNTW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            byte_tick,
    input logic            cfg_we,
    input logic [CNTW-1:0] rate_count,
    input logic            window_done
);
    // R4: the done pulse lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |=> !window_done);

    // R4: the held result moves only together with a done pulse
    a_r4_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !window_done |-> $stable(rate_count));

    // R3: a window closes only on a counted byte strobe
    a_r3_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |-> ($past(byte_tick) && !$past(cfg_we)));

    // R7: a control write never ends a window
    a_r7_cfg_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !window_done);
endmodule

bind err_rate_meter erm_checker #(.CNTW(CNTW)) u_erm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_tick   (byte_tick),
    .cfg_we      (cfg_we),
    .rate_count  (rate_count),
    .window_done (window_done)
);

// File: tb/sim_err_rate_meter.sv
module sim_err_rate_meter;
    localparam int BASE = 4;
    localparam int CW   = 8;
    localparam int EW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [EW-1:0] ev [4];
    logic          byte_tick;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_src = 2'd0;
    logic [1:0]    cfg_period = 2'd0;
    logic [CW-1:0] rate_count;
    logic          window_done;
    logic          tick_alt = 1'b0;
    logic          tick_ph = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tick_ph <= ~tick_ph;
    end
    assign byte_tick = tick_alt ? tick_ph : 1'b1;

    err_rate_meter #(.BASE_LOG2(BASE), .CNTW(CW), .EVW(EW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_demod_bit(ev[0]), .ev_inner_bit(ev[1]),
        .ev_inner_byte(ev[2]), .ev_pkt_fail(ev[3]),
        .byte_tick(byte_tick), .cfg_we(cfg_we),
        .cfg_src(cfg_src), .cfg_period(cfg_period),
        .rate_count(rate_count), .window_done(window_done)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic set_ev(input int a, input int b, input int c, input int d);
        @(negedge clk);
        ev[0] = EW'(a); ev[1] = EW'(b); ev[2] = EW'(c); ev[3] = EW'(d);
    endtask

    // one-cycle control write; returns at the following falling edge
    task automatic write_cfg(input int src, input int per);
        @(negedge clk);
        cfg_src = 2'(src); cfg_period = 2'(per); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // cycles until window_done is seen after a rising edge
    task automatic wait_done(output int n);
        n = 0;
        for (int i = 1; i <= 5000; i++) begin
            @(posedge clk); #1;
            if (window_done) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        check("R1 count", int'(rate_count), 0);
        check("R1 done", int'(window_done), 0);
    endtask

    task automatic t_sources();
        int n;
        for (int s = 0; s < 4; s++) begin
            set_ev(1, 2, 3, 4);
            write_cfg(s, 0);
            wait_done(n);
            check("R3 window 16", n, 16);
            check("R2 R8 source sum", int'(rate_count), 16 * (s + 1));
            @(posedge clk); #1;
            check("R4 done single", int'(window_done), 0);
            wait_done(n);
            check("R5 second window", int'(rate_count), 16 * (s + 1));
            check("R5 second length", n, 15);
        end
    endtask

    task automatic t_periods();
        int n;
        set_ev(0, 0, 0, 0);
        write_cfg(0, 1);
        wait_done(n);
        check("R3 code1 length", n, 64);
        check("R3 code1 count", int'(rate_count), 0);
        write_cfg(0, 2);
        wait_done(n);
        check("R3 code2 length", n, 256);
        write_cfg(0, 3);
        wait_done(n);
        check("R3 code3 length", n, 1024);
    endtask

    task automatic t_saturate();
        int n;
        set_ev(7, 0, 0, 0);
        write_cfg(0, 1);
        wait_done(n);
        check("R6 saturate", int'(rate_count), 255);
        set_ev(1, 0, 0, 0);
        wait_done(n);
        check("R6 R5 after saturation", int'(rate_count), 64);
    endtask

    task automatic t_gated_tick();
        int n;
        set_ev(0, 0, 1, 0);
        write_cfg(2, 0);
        tick_alt = 1'b1;
        wait_done(n);
        check("R3 gated length", (n == 31 || n == 32) ? 1 : 0, 1);
        check("R3 gated count", int'(rate_count), n);
        tick_alt = 1'b0;
    endtask

    task automatic t_cfg_restart();
        int n;
        int seen;
        set_ev(2, 0, 0, 0);
        write_cfg(0, 0);
        wait_done(n);
        check("R4 base count", int'(rate_count), 32);
        set_ev(1, 0, 0, 0);
        repeat (9) @(negedge clk);
        write_cfg(0, 0);
        seen = 0;
        for (int i = 0; i < 15; i++) begin
            @(posedge clk); #1;
            if (window_done) seen++;
        end
        check("R7 no early done", seen, 0);
        check("R7 held kept", int'(rate_count), 32);
        @(posedge clk); #1;
        check("R7 full window done", int'(window_done), 1);
        check("R7 fresh count", int'(rate_count), 16);
    endtask

    initial begin
        ev[0] = '0; ev[1] = '0; ev[2] = '0; ev[3] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_sources();
        t_periods();
        t_saturate();
        t_gated_tick();
        t_cfg_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule